// File: doc/BRIEF.md
# L1 Cache Line Coherence State Controller

This block keeps the coherence state of a small, direct-mapped set of first-level cache lines, each covering an aligned 32-byte block. It sits between the processor's load/store pipeline and the coherent system bus. It decides, for every processor operation and every bus snoop, the line's next state. It also decides whether the operation needs a bus ownership request, whether dirty data must be written back, and whether this cache must supply the line to another agent. Data arrays, tag comparison and bus arbitration are outside the block.

Processor operations are load, store, fill, evict and explicit writeback. A fill carries two flags from address translation: a non-coherent attribute and an exclusive-intent flag. Lines filled with the non-coherent attribute live in two private states that the snoop logic never touches. A store to a Shared line raises an upgrade on the bus and stalls until the line arrives.

A bus request completes in two phases. First comes the ownership order point, then the data landing. If another agent snoops the line between those two phases, the controller still finishes its own pending operation when the data lands. It then hands the line straight on to the other agent, which keeps two writers from starving each other.

Top module: `l1_coh_ctrl`

## Requirements
- R1: After reset every line reads Invalid, no bus request is raised and `cpu_ready` is 1. Line states are 3-bit fields of `line_state` (line n at bits 3n+2..3n), encoded Invalid=0, Shared=1, ExclClean=2, ExclDirty=3, NcClean=4, NcDirty=5.
- R2: The line index is address bits [5+log2(NLINES)-1:5]. Bits [4:0] (the byte within the block) have no effect. A bus request carries the line-aligned address, with bits [4:0] zero.
- R3: A load (`cpu_op`=0) gives `cpu_done`=1 in the cycle after acceptance, with `cpu_hit`=1 only if the line was valid. A load leaves the line state unchanged.
- R4: A fill (`cpu_op`=2) of an Invalid line raises a bus request. Its kind is 3 when the non-coherent flag is set, 1 when the exclusive flag is set, and 0 otherwise. On ownership followed by data landing, the line becomes NcClean, ExclClean or Shared respectively, and `cpu_done`=1 with `cpu_hit`=0 appears in the cycle after the data.
- R5: A store (`cpu_op`=1) moves ExclClean or ExclDirty to ExclDirty, and NcClean or NcDirty to NcDirty. It raises no bus request, and gives `cpu_done`=1 with `cpu_hit`=1 in the cycle after acceptance. A store to an Invalid line completes with `cpu_hit`=0 and no state change.
- R6: A store to a Shared line raises a bus request of kind 2 (upgrade) and gives no `cpu_done` until the data lands. It then completes with `cpu_hit`=1 and the line in ExclDirty.
- R7: An evict (`cpu_op`=3) moves any line to Invalid and pulses `cpu_wb` only if the line was ExclDirty or NcDirty. A writeback (`cpu_op`=4) moves ExclDirty to ExclClean and NcDirty to NcClean with a `cpu_wb` pulse. It does nothing to other states.
- R8: A snoop of either kind that hits an NcClean or NcDirty line changes no state and produces no `snp_supply` or `snp_wb`.
- R9: A snoop hitting a Shared line never asserts `snp_supply`. An exclusive snoop (`snp_excl`=1) moves the line to Invalid, and a shared snoop leaves it Shared.
- R10: A snoop hitting ExclClean or ExclDirty asserts `snp_supply` in the next cycle, with `snp_wb` as well when the line was ExclDirty. The line goes to Invalid on an exclusive snoop and to Shared on a shared snoop.
- R11: A snoop that hits a line whose request has been granted ownership but whose data has not landed gives no immediate response. When the data lands, the pending operation completes (`cpu_done`), `snp_supply` is asserted with `snp_wb` if the operation was a store, and the line ends Invalid (exclusive snoop) or Shared (shared snoop).
- R12: While a bus request is outstanding, or while a snoop is presented, `cpu_ready` is 0 and no further processor operation is accepted. A raised request holds its kind and address until ownership is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor operation presented |
| cpu_op | input | 3 | 0 load, 1 store, 2 fill, 3 evict, 4 writeback |
| cpu_addr | input | ADDR_W | Operation address |
| cpu_nc | input | 1 | Fill attribute: cacheable non-coherent |
| cpu_excl | input | 1 | Fill intent: request exclusive ownership |
| cpu_ready | output | 1 | Operation can be accepted this cycle |
| cpu_done | output | 1 | Operation completed (one-cycle pulse) |
| cpu_hit | output | 1 | Completed operation found a valid line |
| cpu_wb | output | 1 | Processor-caused dirty writeback (pulse) |
| bus_req_valid | output | 1 | Ownership/read request outstanding |
| bus_req_kind | output | 2 | 0 read shared, 1 read exclusive, 2 upgrade, 3 non-coherent read |
| bus_req_addr | output | ADDR_W | Line-aligned request address |
| bus_own | input | 1 | Ownership granted to the outstanding request |
| bus_data | input | 1 | Data for the owned request has landed |
| snp_valid | input | 1 | Bus snoop presented |
| snp_excl | input | 1 | Snoop requests exclusive ownership |
| snp_addr | input | ADDR_W | Snoop address |
| snp_supply | output | 1 | This cache supplies the snooped line (pulse) |
| snp_wb | output | 1 | Supplied line is dirty and written back (pulse) |
| line_state | output | 3*NLINES | Packed per-line state |

## Verification
The checker assumes that the bus delivers `bus_own` only while a request is raised and `bus_data` only after ownership. It also assumes that a snoop is never presented in the same cycle as `bus_data` or `bus_own`, and that the processor presents an operation only while `cpu_ready` is high. The directed bench drives each bus handshake input, and each snoop, in a cycle of its own, one cycle apart. It issues processor operations only when no request is pending. The lost-ownership sequence is the only place where a snoop falls between ownership and data, and there it is placed deliberately.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [2:0] {
      ST_I = 3'd0, ST_S = 3'd1, ST_EC = 3'd2,
      ST_ED = 3'd3, ST_NC = 3'd4, ST_ND = 3'd5
   } lstate_t;

   typedef enum logic [2:0] {
      OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_FILL = 3'd2,
      OP_EVICT = 3'd3, OP_WBACK = 3'd4
   } cpu_op_t;

   typedef enum logic [1:0] {
      BK_RDSH = 2'd0, BK_RDEX = 2'd1, BK_UPG = 2'd2, BK_RDNC = 2'd3
   } bkind_t;

   function automatic logic st_valid(lstate_t s);
      return s != ST_I;
   endfunction
endpackage

// File: rtl/coh_cpu_xfer.sv
module coh_cpu_xfer
   import coh_pkg::*;
(
   input  logic [2:0] op_i,
   input  lstate_t    cur_i,
   input  logic       nc_i,
   input  logic       excl_i,
   output lstate_t    nxt_o,
   output logic       need_bus_o,
   output bkind_t     kind_o,
   output logic       hit_o,
   output logic       wb_o
);
   always_comb begin
      nxt_o      = cur_i;
      need_bus_o = 1'b0;
      kind_o     = BK_RDSH;
      hit_o      = st_valid(cur_i);
      wb_o       = 1'b0;
      case (cpu_op_t'(op_i))
         OP_LOAD: ;
         OP_STORE: begin
            case (cur_i)
               ST_S: begin
                  need_bus_o = 1'b1;
                  kind_o     = BK_UPG;
               end
               ST_EC, ST_ED: nxt_o = ST_ED;
               ST_NC, ST_ND: nxt_o = ST_ND;
               default: ;
            endcase
         end
         OP_FILL: begin
            if (cur_i == ST_I) begin
               need_bus_o = 1'b1;
               kind_o     = nc_i ? BK_RDNC : (excl_i ? BK_RDEX : BK_RDSH);
            end
         end
         OP_EVICT: begin
            wb_o  = (cur_i == ST_ED) || (cur_i == ST_ND);
            nxt_o = ST_I;
         end
         OP_WBACK: begin
            if (cur_i == ST_ED) begin
               nxt_o = ST_EC;
               wb_o  = 1'b1;
            end else if (cur_i == ST_ND) begin
               nxt_o = ST_NC;
               wb_o  = 1'b1;
            end
         end
         default: hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/coh_snoop_xfer.sv
module coh_snoop_xfer
   import coh_pkg::*;
(
   input  lstate_t cur_i,
   input  logic    excl_i,
   output lstate_t nxt_o,
   output logic    supply_o,
   output logic    wb_o
);
   always_comb begin
      nxt_o    = cur_i;
      supply_o = 1'b0;
      wb_o     = 1'b0;
      case (cur_i)
         ST_S:  nxt_o = excl_i ? ST_I : ST_S;
         ST_EC: begin
            supply_o = 1'b1;
            nxt_o    = excl_i ? ST_I : ST_S;
         end
         ST_ED: begin
            supply_o = 1'b1;
            wb_o     = 1'b1;
            nxt_o    = excl_i ? ST_I : ST_S;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/coh_pend_slot.sv
module coh_pend_slot
   import coh_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] start_idx_i,
   input  bkind_t           start_kind_i,
   input  logic             start_store_i,
   input  logic             own_i,
   input  logic             data_i,
   input  logic             lose_i,
   input  logic             lose_ex_i,
   output logic             v_o,
   output logic [IDX_W-1:0] idx_o,
   output bkind_t           kind_o,
   output logic             store_o,
   output logic             owned_o,
   output logic             lost_o,
   output logic             lost_ex_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o       <= 1'b0;
         idx_o     <= '0;
         kind_o    <= BK_RDSH;
         store_o   <= 1'b0;
         owned_o   <= 1'b0;
         lost_o    <= 1'b0;
         lost_ex_o <= 1'b0;
      end else if (start_i && !v_o) begin
         v_o       <= 1'b1;
         idx_o     <= start_idx_i;
         kind_o    <= start_kind_i;
         store_o   <= start_store_i;
         owned_o   <= 1'b0;
         lost_o    <= 1'b0;
         lost_ex_o <= 1'b0;
      end else if (v_o && !owned_o && own_i) begin
         owned_o <= 1'b1;
      end else if (v_o && owned_o && data_i) begin
         v_o     <= 1'b0;
         owned_o <= 1'b0;
         lost_o  <= 1'b0;
      end else if (v_o && owned_o && lose_i) begin
         lost_o    <= 1'b1;
         lost_ex_o <= lost_ex_o | lose_ex_i;
      end
   end
endmodule

// File: rtl/l1_coh_ctrl.sv
module l1_coh_ctrl
   import coh_pkg::*;
#(
   parameter int NLINES     = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_valid,
   input  logic [2:0]            cpu_op,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic                  cpu_nc,
   input  logic                  cpu_excl,
   output logic                  cpu_ready,
   output logic                  cpu_done,
   output logic                  cpu_hit,
   output logic                  cpu_wb,
   output logic                  bus_req_valid,
   output logic [1:0]            bus_req_kind,
   output logic [ADDR_W-1:0]     bus_req_addr,
   input  logic                  bus_own,
   input  logic                  bus_data,
   input  logic                  snp_valid,
   input  logic                  snp_excl,
   input  logic [ADDR_W-1:0]     snp_addr,
   output logic                  snp_supply,
   output logic                  snp_wb,
   output logic [3*NLINES-1:0]   line_state
);
   localparam int OFFS  = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(NLINES);

   generate
      if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_lines
         $error("NLINES must be a power of two, at least 2");
      end
      if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two, at least 2");
      end
      if (ADDR_W <= OFFS + IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for line index and offset");
      end
   endgenerate

   logic [IDX_W-1:0] cpu_idx, snp_idx;
   lstate_t cur_cpu, cur_snp, cpu_nxt, snp_nxt, land_st;
   logic    need_bus, cpu_hit_c, cpu_wb_c, snp_sup_c, snp_wb_c;
   bkind_t  cpu_kind;
   logic             pend_v, pend_store, pend_owned, pend_lost, pend_lost_ex;
   logic [IDX_W-1:0] pend_idx;
   bkind_t           pend_kind;
   logic cpu_go, start, snp_on_pend, snp_apply, land;

   assign cpu_idx = cpu_addr[OFFS +: IDX_W];
   assign snp_idx = snp_addr[OFFS +: IDX_W];
   assign cur_cpu = lstate_t'(line_state[int'(cpu_idx)*3 +: 3]);
   assign cur_snp = lstate_t'(line_state[int'(snp_idx)*3 +: 3]);

   assign cpu_ready = !pend_v && !snp_valid;
   assign cpu_go    = cpu_valid && cpu_ready;
   assign start     = cpu_go && need_bus;

   coh_cpu_xfer u_cpu (
      .op_i(cpu_op), .cur_i(cur_cpu), .nc_i(cpu_nc), .excl_i(cpu_excl),
      .nxt_o(cpu_nxt), .need_bus_o(need_bus), .kind_o(cpu_kind),
      .hit_o(cpu_hit_c), .wb_o(cpu_wb_c)
   );

   coh_snoop_xfer u_snp (
      .cur_i(cur_snp), .excl_i(snp_excl),
      .nxt_o(snp_nxt), .supply_o(snp_sup_c), .wb_o(snp_wb_c)
   );

   assign snp_on_pend = snp_valid && pend_v && pend_owned &&
                        (pend_kind != BK_RDNC) && (snp_idx == pend_idx);
   assign snp_apply   = snp_valid && !snp_on_pend;
   assign land        = bus_data && pend_v && pend_owned;

   coh_pend_slot #(.IDX_W(IDX_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .start_idx_i(cpu_idx), .start_kind_i(cpu_kind),
      .start_store_i(cpu_op == OP_STORE),
      .own_i(bus_own), .data_i(bus_data),
      .lose_i(snp_on_pend), .lose_ex_i(snp_excl),
      .v_o(pend_v), .idx_o(pend_idx), .kind_o(pend_kind), .store_o(pend_store),
      .owned_o(pend_owned), .lost_o(pend_lost), .lost_ex_o(pend_lost_ex)
   );

   always_comb begin
      case (pend_kind)
         BK_RDNC: land_st = ST_NC;
         BK_RDSH: land_st = ST_S;
         BK_RDEX: land_st = ST_EC;
         default: land_st = ST_ED;
      endcase
      if (pend_store) land_st = ST_ED;
      if (pend_lost)  land_st = pend_lost_ex ? ST_I : ST_S;
   end

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         lstate_t st_r;
         always_ff @(posedge clk) begin
            if (!rst_n)
               st_r <= ST_I;
            else if (land && pend_idx == IDX_W'(i))
               st_r <= land_st;
            else if (snp_apply && snp_idx == IDX_W'(i))
               st_r <= snp_nxt;
            else if (cpu_go && !need_bus && cpu_idx == IDX_W'(i))
               st_r <= cpu_nxt;
         end
         assign line_state[i*3 +: 3] = st_r;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_done   <= 1'b0;
         cpu_hit    <= 1'b0;
         cpu_wb     <= 1'b0;
         snp_supply <= 1'b0;
         snp_wb     <= 1'b0;
      end else begin
         cpu_done   <= (cpu_go && !need_bus) || land;
         cpu_hit    <= land ? pend_store : (cpu_go && !need_bus && cpu_hit_c);
         cpu_wb     <= cpu_go && !need_bus && cpu_wb_c;
         snp_supply <= (snp_apply && snp_sup_c) || (land && pend_lost);
         snp_wb     <= (snp_apply && snp_wb_c) || (land && pend_lost && pend_store);
      end
   end

   assign bus_req_valid = pend_v && !pend_owned;
   assign bus_req_kind  = pend_kind;
   assign bus_req_addr  = ADDR_W'({pend_idx, {OFFS{1'b0}}});

   logic unused_bits;
   assign unused_bits = ^{cpu_addr[ADDR_W-1:OFFS+IDX_W], cpu_addr[OFFS-1:0],
                          snp_addr[ADDR_W-1:OFFS+IDX_W], snp_addr[OFFS-1:0]};
endmodule

// File: rtl/l1_coh_ctrl_chk.sv
module l1_coh_ctrl_chk #(
   parameter int NLINES     = 4,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_valid,
   input logic [2:0]          cpu_op,
   input logic [ADDR_W-1:0]   cpu_addr,
   input logic                cpu_ready,
   input logic                cpu_wb,
   input logic                bus_req_valid,
   input logic [1:0]          bus_req_kind,
   input logic [ADDR_W-1:0]   bus_req_addr,
   input logic                bus_own,
   input logic                snp_valid,
   input logic [ADDR_W-1:0]   snp_addr,
   input logic                snp_supply,
   input logic                snp_wb,
   input logic [3*NLINES-1:0] line_state
);
   localparam int OFFS  = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(NLINES);

   logic [IDX_W-1:0] c_idx, s_idx;
   logic [2:0]       c_st, s_st;
   assign c_idx = cpu_addr[OFFS +: IDX_W];
   assign s_idx = snp_addr[OFFS +: IDX_W];
   assign c_st  = line_state[int'(c_idx)*3 +: 3];
   assign s_st  = line_state[int'(s_idx)*3 +: 3];

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_enc
         // R1
         state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_state[i*3 +: 3] <= 3'd5);
      end
   endgenerate

   // R6
   store_shared_upg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && cpu_op == 3'd1 && c_st == 3'd1
      |=> bus_req_valid && bus_req_kind == 2'd2);

   // R7
   evict_dirty_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_valid && cpu_ready && cpu_op == 3'd3 && (c_st == 3'd3 || c_st == 3'd5)
      |=> cpu_wb);

   // R8
   nc_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && (s_st == 3'd4 || s_st == 3'd5)
      |=> !snp_supply && !snp_wb && $stable(line_state));

   // R9
   shared_no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && s_st == 3'd1 |=> !snp_supply);

   // R10
   dirty_snoop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && s_st == 3'd3 |=> snp_supply && snp_wb);

   // R10
   wb_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> snp_supply);

   // R12
   snoop_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_ready);

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_own
      |=> bus_req_valid && $stable(bus_req_kind) && $stable(bus_req_addr));

   // R2
   req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> bus_req_addr[OFFS-1:0] == '0);
endmodule

bind l1_coh_ctrl l1_coh_ctrl_chk #(
   .NLINES(NLINES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
   .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_wb(cpu_wb),
   .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
   .bus_req_addr(bus_req_addr), .bus_own(bus_own), .snp_valid(snp_valid),
   .snp_addr(snp_addr), .snp_supply(snp_supply), .snp_wb(snp_wb),
   .line_state(line_state)
);

// File: tb/l1_coh_ctrl_tb_top.sv
module l1_coh_ctrl_tb_top;
   localparam int NL = 4;
   localparam int AW = 32;
   localparam logic [2:0] LD = 3'd0, STO = 3'd1, FIL = 3'd2, EVI = 3'd3, WBK = 3'd4;
   localparam int SI = 0, SS = 1, SEC = 2, SED = 3, SNC = 4, SND = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_valid = 1'b0, cpu_nc = 1'b0, cpu_excl = 1'b0;
   logic [2:0] cpu_op = 3'd0;
   logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
   logic bus_own = 1'b0, bus_data = 1'b0, snp_valid = 1'b0, snp_excl = 1'b0;
   logic cpu_ready, cpu_done, cpu_hit, cpu_wb, bus_req_valid, snp_supply, snp_wb;
   logic [1:0] bus_req_kind;
   logic [AW-1:0] bus_req_addr;
   logic [3*NL-1:0] line_state;

   int n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   l1_coh_ctrl #(.NLINES(NL), .ADDR_W(AW), .LINE_BYTES(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
      .cpu_addr(cpu_addr), .cpu_nc(cpu_nc), .cpu_excl(cpu_excl),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_wb(cpu_wb),
      .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
      .bus_req_addr(bus_req_addr), .bus_own(bus_own), .bus_data(bus_data),
      .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
      .snp_supply(snp_supply), .snp_wb(snp_wb), .line_state(line_state)
   );

   function automatic int st(int i);
      return int'(line_state[i*3 +: 3]);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cpu(logic [2:0] op, logic [AW-1:0] a, logic nc, logic ex);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_nc = nc; cpu_excl = ex;
      @(negedge clk);
      cpu_valid = 1'b0; cpu_nc = 1'b0; cpu_excl = 1'b0;
   endtask

   task automatic own();
      @(negedge clk); bus_own = 1'b1;
      @(negedge clk); bus_own = 1'b0;
   endtask

   task automatic land();
      @(negedge clk); bus_data = 1'b1;
      @(negedge clk); bus_data = 1'b0;
   endtask

   task automatic snoop(logic [AW-1:0] a, logic ex, string req);
      @(negedge clk);
      snp_valid = 1'b1; snp_addr = a; snp_excl = ex;
      #1 chk(req, "ready during snoop", int'(cpu_ready), 0);
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic fill_line(logic [AW-1:0] a, logic nc, logic ex, int kind, int line, int fin, string req);
      cpu(FIL, a, nc, ex);
      chk(req, "fill req valid", int'(bus_req_valid), 1);
      chk(req, "fill req kind", int'(bus_req_kind), kind);
      chk(req, "fill req addr", int'(bus_req_addr), line * 32);
      own();
      land();
      chk(req, "fill done", int'(cpu_done), 1);
      chk(req, "fill hit", int'(cpu_hit), 0);
      chk(req, "fill state", st(line), fin);
   endtask

   task automatic t_reset();
      for (int i = 0; i < NL; i++) chk("R1", "reset state", st(i), SI);
      chk("R1", "reset req", int'(bus_req_valid), 0);
      chk("R1", "reset ready", int'(cpu_ready), 1);
   endtask

   task automatic t_load();
      cpu(LD, 32'h0000_0004, 1'b0, 1'b0);
      chk("R3", "load miss done", int'(cpu_done), 1);
      chk("R3", "load miss hit", int'(cpu_hit), 0);
      chk("R3", "load miss state", st(0), SI);
      fill_line(32'h0, 1'b0, 1'b0, 0, 0, SS, "R4");
      cpu(LD, 32'h0000_0010, 1'b0, 1'b0);
      chk("R3", "load hit", int'(cpu_hit), 1);
      chk("R3", "load keeps state", st(0), SS);
   endtask

   task automatic t_upgrade();
      cpu(STO, 32'h0000_0008, 1'b0, 1'b0);
      chk("R6", "upgrade kind", int'(bus_req_kind), 2);
      chk("R6", "upgrade req", int'(bus_req_valid), 1);
      chk("R6", "store stalled", int'(cpu_done), 0);
      repeat (3) @(negedge clk);
      chk("R6", "still stalled", int'(cpu_done), 0);
      chk("R12", "ready while pending", int'(cpu_ready), 0);
      chk("R6", "state still shared", st(0), SS);
      own();
      chk("R12", "ready after own, before data", int'(cpu_ready), 0);
      land();
      chk("R6", "upgrade done", int'(cpu_done), 1);
      chk("R6", "upgrade hit", int'(cpu_hit), 1);
      chk("R6", "upgrade state", st(0), SED);
      chk("R12", "ready after data", int'(cpu_ready), 1);
   endtask

   task automatic t_silent();
      fill_line(32'h0000_0020, 1'b0, 1'b1, 1, 1, SEC, "R4");
      cpu(STO, 32'h0000_003C, 1'b0, 1'b0);
      chk("R5", "silent store done", int'(cpu_done), 1);
      chk("R5", "silent store hit", int'(cpu_hit), 1);
      chk("R5", "silent no req", int'(bus_req_valid), 0);
      chk("R5", "silent store state", st(1), SED);
      cpu(WBK, 32'h0000_0020, 1'b0, 1'b0);
      chk("R7", "wback wb", int'(cpu_wb), 1);
      chk("R7", "wback state", st(1), SEC);
      cpu(WBK, 32'h0000_0020, 1'b0, 1'b0);
      chk("R7", "clean wback no wb", int'(cpu_wb), 0);
      chk("R7", "clean wback state", st(1), SEC);
   endtask

   task automatic t_evict();
      cpu(EVI, 32'h0000_0000, 1'b0, 1'b0);
      chk("R7", "evict dirty wb", int'(cpu_wb), 1);
      chk("R7", "evict dirty state", st(0), SI);
      cpu(EVI, 32'h0000_0020, 1'b0, 1'b0);
      chk("R7", "evict clean no wb", int'(cpu_wb), 0);
      chk("R7", "evict clean state", st(1), SI);
      cpu(STO, 32'h0000_0020, 1'b0, 1'b0);
      chk("R5", "store invalid done", int'(cpu_done), 1);
      chk("R5", "store invalid hit", int'(cpu_hit), 0);
      chk("R5", "store invalid state", st(1), SI);
   endtask

   task automatic t_noncoh();
      // offset bits 0x1F set: still line 2, request aligned to 0x40 (R2)
      fill_line(32'h0000_005F, 1'b1, 1'b0, 3, 2, SNC, "R2");
      cpu(STO, 32'h0000_0040, 1'b0, 1'b0);
      chk("R5", "nc store state", st(2), SND);
      snoop(32'h0000_0040, 1'b1, "R12");
      chk("R8", "nc excl snoop supply", int'(snp_supply), 0);
      chk("R8", "nc excl snoop wb", int'(snp_wb), 0);
      chk("R8", "nc excl snoop state", st(2), SND);
      snoop(32'h0000_0044, 1'b0, "R12");
      chk("R8", "nc shared snoop supply", int'(snp_supply), 0);
      chk("R8", "nc shared snoop state", st(2), SND);
      cpu(WBK, 32'h0000_0041, 1'b0, 1'b0);
      chk("R7", "nc wback wb", int'(cpu_wb), 1);
      chk("R7", "nc wback state", st(2), SNC);
   endtask

   task automatic t_shared_snoop();
      fill_line(32'h0000_0060, 1'b0, 1'b0, 0, 3, SS, "R4");
      snoop(32'h0000_0060, 1'b0, "R12");
      chk("R9", "shared rd snoop supply", int'(snp_supply), 0);
      chk("R9", "shared rd snoop state", st(3), SS);
      snoop(32'h0000_0070, 1'b1, "R12");
      chk("R9", "shared excl snoop supply", int'(snp_supply), 0);
      chk("R9", "shared excl snoop state", st(3), SI);
   endtask

   task automatic t_interv();
      fill_line(32'h0000_0020, 1'b0, 1'b1, 1, 1, SEC, "R4");
      snoop(32'h0000_0020, 1'b0, "R12");
      chk("R10", "ec rd snoop supply", int'(snp_supply), 1);
      chk("R10", "ec rd snoop wb", int'(snp_wb), 0);
      chk("R10", "ec rd snoop state", st(1), SS);
      cpu(STO, 32'h0000_0020, 1'b0, 1'b0);
      own();
      land();
      chk("R6", "second upgrade state", st(1), SED);
      snoop(32'h0000_0020, 1'b1, "R12");
      chk("R10", "ed excl snoop supply", int'(snp_supply), 1);
      chk("R10", "ed excl snoop wb", int'(snp_wb), 1);
      chk("R10", "ed excl snoop state", st(1), SI);
      fill_line(32'h0000_0060, 1'b0, 1'b1, 1, 3, SEC, "R4");
      snoop(32'h0000_0060, 1'b1, "R12");
      chk("R10", "ec excl snoop supply", int'(snp_supply), 1);
      chk("R10", "ec excl snoop wb", int'(snp_wb), 0);
      chk("R10", "ec excl snoop state", st(3), SI);
   endtask

   task automatic t_lost();
      fill_line(32'h0, 1'b0, 1'b0, 0, 0, SS, "R4");
      cpu(STO, 32'h0, 1'b0, 1'b0);
      own();
      snoop(32'h0000_0004, 1'b1, "R12");
      chk("R11", "no early supply", int'(snp_supply), 0);
      chk("R11", "no early done", int'(cpu_done), 0);
      land();
      chk("R11", "lost store done", int'(cpu_done), 1);
      chk("R11", "lost store hit", int'(cpu_hit), 1);
      chk("R11", "lost store supply", int'(snp_supply), 1);
      chk("R11", "lost store wb", int'(snp_wb), 1);
      chk("R11", "lost store state", st(0), SI);
      cpu(EVI, 32'h0000_0040, 1'b0, 1'b0);
      chk("R7", "evict nc clean", int'(cpu_wb), 0);
      cpu(FIL, 32'h0000_0040, 1'b0, 1'b1);
      own();
      snoop(32'h0000_0040, 1'b0, "R12");
      land();
      chk("R11", "lost fill done", int'(cpu_done), 1);
      chk("R11", "lost fill supply", int'(snp_supply), 1);
      chk("R11", "lost fill wb", int'(snp_wb), 0);
      chk("R11", "lost fill state", st(2), SS);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_upgrade();
      t_silent();
      t_evict();
      t_noncoh();
      t_shared_snoop();
      t_interv();
      t_lost();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule